// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. It watches a clock line and a data line, both already synchronized to the system clock. It pulls the data line low through an open-drain enable. It finds start and stop conditions and checks the device select byte against three strap inputs. For a write it takes a 16-bit word address, high byte first, and then any number of data bytes. Those bytes collect in a page buffer and go to a small internal byte array in a timed commit cycle that begins at the stop condition.

During the commit cycle the slave lets go of the bus completely. A master can therefore find the end of the cycle by sending the select byte again until it is acknowledged. Reads return bytes from the current address, one after another. After a dummy write that only loads the address, a repeated start begins a read at any chosen location.

The array holds 2^ARRAY_AW bytes. The default is 1024, so that the block stays small when elaborated with default parameters. Word addresses wrap onto the array modulo its size. The page holds 2^PAGE_AW bytes, 128 by default. The commit cycle lasts WRITE_CYCLES system clocks, and WRITE_CYCLES must be at least the page size.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the slave is idle and `sda_oe_o` is 0, which leaves SDA released.
- R2: The select byte is sent MSB first. Its bits 7:4 must be 1010 and its bits 3:1 must equal `sel_i[2:0]`. Bit 0 is the direction: 1 means read and 0 means write. On a match the slave pulls SDA low for the ninth clock. On a mismatch it does not acknowledge, and it ignores the bus until the next start condition.
- R3: In a write, the two bytes after the select byte are the word address, high byte first. The slave acknowledges both. It also acknowledges every data byte that follows.
- R4: A stop condition that follows at least one complete data byte starts a commit cycle of WRITE_CYCLES clocks. After that cycle the written bytes can be read back from the array.
- R5: After each data byte, only word-address bits 6:0 advance, modulo 128. Bits 15:7 keep their value, so bytes beyond the last offset of a page continue at offset 0 of the same page.
- R6: When more than 128 data bytes are sent in one write, each later byte replaces the earlier byte at the same page offset.
- R7: For the whole commit cycle `sda_oe_o` stays 0. No select byte is acknowledged, and start and stop conditions have no effect. Once the cycle ends, a matching select byte is acknowledged again.
- R8: If `wp_i` is 1 when the stop condition arrives, the array is left unchanged and no commit cycle starts. The data bytes of that write are still acknowledged.
- R9: A start or stop condition ends the transfer in progress at any point. A stop condition or a repeated start with no complete data byte starts no commit cycle. The word address that was received remains the current address.
- R10: A read sends the byte at the current address, MSB first. After each byte the full 16-bit address increases by one, so a read carries on past page boundaries. An acknowledge from the master brings the next byte, and a not-acknowledge ends the read.
- R11: `sda_oe_o` becomes active only in the cycle after a falling SCL edge is seen. It is never active while the master is sending a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (wired level) |
| sel_i | input | 3 | Strapped device select bits |
| wp_i | input | 1 | Write protect; 1 blocks array updates |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
Some properties are checked by assertions on every cycle, next to the logic they guard:
- the data enable stays off during the commit cycle;
- the enable rises only after a falling clock edge;
- a mismatched select byte sends the slave to idle with the line released;
- the page row is kept when a data byte is taken;
- a stop under write protect, or a stop with no data, never enters the commit cycle.

Other behaviour can only be shown by the bench scenarios, which compare read data against a behavioural byte model:
- page wrap and overwrite with more than 128 bytes;
- reads that cross a page boundary;
- refused acknowledges while a write is being polled;
- current-address reads after an aborted transfer.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_BUSY
  } phase_e;

  typedef enum logic [1:0] {
    RK_DEV, RK_AHI, RK_ALO, RK_DATA
  } rxkind_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // select byte compare: type nibble and strap bits, direction excluded
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
  endfunction

  // advance only the in-page bits, keep the row
  function automatic logic [15:0] page_step(input logic [15:0] a, input int unsigned paw);
    logic [15:0] m;
    m = 16'((32'd1 << paw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  function automatic rxkind_e next_kind(input rxkind_e k);
    case (k)
      RK_DEV:  return RK_AHI;
      RK_AHI:  return RK_ALO;
      default: return RK_DATA;
    endcase
  endfunction
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  // data edges while the clock is held high
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [PAGE_AW-1:0] wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [PAGE_AW-1:0] rd_idx,
  output logic               rd_valid,
  output logic [7:0]         rd_data
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clr) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ARRAY_AW     = 10,
  parameter int PAGE_AW      = 7,
  parameter int WRITE_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int TW         = $clog2(WRITE_CYCLES + 1);

  logic scl_rise, scl_fall, start_c, stop_c;

  phase_e     phase;
  rxkind_e    kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh;
  logic       rw, wr_seq, have_data, mack_ok;
  logic [15:0] addr;
  logic [TW-1:0] busy_cnt;

  // named internal events
  logic byte_eval, dev_ok, commit_go, in_commit, mem_we, pb_valid;
  logic [PAGE_AW-1:0]  commit_idx;
  logic [ARRAY_AW-1:0] commit_word;
  logic [7:0] pb_data, rd_byte;

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_i), .sda(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  assign byte_eval  = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
  assign dev_ok     = dev_hit(shreg, sel_i);
  assign commit_go  = stop_c && wr_seq && have_data && !wp_i;
  assign commit_idx = busy_cnt[PAGE_AW-1:0];
  assign in_commit  = (phase == PH_BUSY) && (32'(busy_cnt) < PAGE_BYTES);
  assign mem_we     = in_commit && pb_valid;
  assign commit_word = ARRAY_AW'({addr[15:PAGE_AW], commit_idx});

  eep_page_buf #(.PAGE_AW(PAGE_AW)) u_page (
    .clk(clk), .rst_n(rst_n),
    .clr(byte_eval && kind == RK_ALO),
    .wr_en(byte_eval && kind == RK_DATA),
    .wr_idx(addr[PAGE_AW-1:0]), .wr_data(shreg),
    .rd_idx(commit_idx), .rd_valid(pb_valid), .rd_data(pb_data)
  );

  eep_array #(.AW(ARRAY_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(commit_word), .wdata(pb_data),
    .raddr(addr[ARRAY_AW-1:0]), .rdata(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; kind <= RK_DEV; bitcnt <= '0; shreg <= '0; txsh <= '0;
      rw <= 1'b0; wr_seq <= 1'b0; have_data <= 1'b0; mack_ok <= 1'b0;
      addr <= '0; busy_cnt <= '0;
    end else if (phase == PH_BUSY) begin
      busy_cnt <= busy_cnt + 1'b1;
      if (busy_cnt == TW'(WRITE_CYCLES - 1)) phase <= PH_IDLE;
    end else if (start_c) begin
      phase <= PH_RX; kind <= RK_DEV; bitcnt <= '0;
      wr_seq <= 1'b0; have_data <= 1'b0;
    end else if (stop_c) begin
      phase <= commit_go ? PH_BUSY : PH_IDLE;
      busy_cnt <= '0; wr_seq <= 1'b0; have_data <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_i};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_eval) begin
            phase <= PH_ACK;
            case (kind)
              RK_DEV: begin
                rw <= shreg[0];
                if (!dev_ok) phase <= PH_IDLE;
              end
              RK_AHI: addr[15:8] <= shreg;
              RK_ALO: begin addr[7:0] <= shreg; wr_seq <= 1'b1; end
              default: begin addr <= page_step(addr, PAGE_AW); have_data <= 1'b1; end
            endcase
          end
        end
        PH_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (kind == RK_DEV && rw) begin
            txsh <= rd_byte; phase <= PH_TX;
          end else begin
            kind <= next_kind(kind); phase <= PH_RX;
          end
        end
        PH_TX: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            phase <= PH_MACK; addr <= addr + 16'd1;
          end else begin
            txsh <= {txsh[6:0], 1'b0}; bitcnt <= bitcnt + 4'd1;
          end
        end
        PH_MACK: begin
          if (scl_rise) mack_ok <= ~sda_i;
          else if (scl_fall) begin
            bitcnt <= '0;
            if (mack_ok) begin txsh <= rd_byte; phase <= PH_TX; end
            else phase <= PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (phase == PH_ACK) || (phase == PH_TX && !txsh[7]);

  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUSY) |-> !sda_oe_o);

  a_r11_oe_rise_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  a_r2_nomatch_release: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_eval && kind == RK_DEV && !dev_ok) |=> (!sda_oe_o && phase == PH_IDLE));

  a_r5_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_eval && kind == RK_DATA) |=> (addr[15:PAGE_AW] == $past(addr[15:PAGE_AW])));

  a_r8_wp_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && wp_i && phase != PH_BUSY) |=> (phase != PH_BUSY));

  a_r9_empty_stop_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !have_data && phase != PH_BUSY) |=> (phase != PH_BUSY));
endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int Q  = 4;
  localparam int WC = 300;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  serial_eeprom_slave #(.WRITE_CYCLES(WC)) i_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sel_i(sel), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  int checks = 0, errors = 0;
  bit quiet = 1'b0;
  logic [7:0] mm [1024];
  int cur = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-clock reference: nothing driven while a commit window is known to be open
  always @(negedge clk) if (quiet) chk("R7 line released in commit cycle", int'(sda_oe), 0);

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q);
    chk("R11 no drive while master sends", int'(sda_oe), 0);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, string req, int exp_ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    chk(req, int'(!sda_line), exp_ack);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(bit mack, output logic [7:0] got);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); got[i] = sda_line; scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic poll(string req, int exp_ack);
    bus_start(); send_byte(8'hAA, req, exp_ack); bus_stop();
  endtask

  task automatic write_txn(int a, logic [7:0] q[$], string req);
    bus_start();
    send_byte(8'hAA, req, 1);
    send_byte(8'(a >> 8), req, 1);
    send_byte(8'(a), req, 1);
    foreach (q[i]) send_byte(q[i], req, 1);
    bus_stop();
    if (q.size() > 0 && !wp)
      foreach (q[i]) mm[((a & 16'hFF80) | ((a + i) & 7'h7F)) % 1024] = q[i];
    cur = (a & 16'hFF80) | ((a + q.size()) & 7'h7F);
  endtask

  task automatic read_at(int a, int n, string req);
    logic [7:0] got;
    bus_start();
    send_byte(8'hAA, req, 1);
    send_byte(8'(a >> 8), req, 1);
    send_byte(8'(a), req, 1);
    bus_start();
    send_byte(8'hAB, req, 1);
    cur = a;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, got);
      chk(req, int'(got), int'(mm[cur % 1024]));
      cur = (cur + 1) % 65536;
    end
    bus_stop();
  endtask

  task automatic wait_commit();
    quiet = 1'b1; tick(WC - 20); quiet = 1'b0; tick(40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] got;
    for (int i = 0; i < 1024; i++) mm[i] = 8'h00;
    tick(3); rst_n = 1'b1; tick(2);
    chk("R1 released after reset", int'(sda_oe), 0);

    // R2: wrong strap bits, then a byte with no start must stay unanswered
    bus_start();
    send_byte(8'hA2, "R2 mismatch not acked", 0);
    send_byte(8'hAA, "R2 ignored until next start", 0);
    bus_stop();
    poll("R2 match acked", 1);

    // R3 R4 R7: byte write, poll during the cycle, poll after
    q = '{8'hA5};
    write_txn(16'h0012, q, "R3 write acks");
    quiet = 1'b1;
    poll("R7 no ack during commit", 0);
    quiet = 1'b0;
    tick(WC);
    poll("R7 ack after commit", 1);
    read_at(16'h0012, 1, "R4 byte written");

    // R5: page write wrapping from offset 0x78; R10 read across page end
    q = {};
    for (int i = 0; i < 12; i++) q.push_back(8'(8'h10 + i));
    write_txn(16'h0178, q, "R3 page acks");
    wait_commit();
    read_at(16'h0100, 4, "R5 wrapped to page start");
    read_at(16'h0178, 10, "R10 read crosses page");

    // R6: 130 bytes, first two offsets overwritten
    q = {};
    for (int i = 0; i < 130; i++) q.push_back(8'(i));
    write_txn(16'h0200, q, "R6 long page acks");
    wait_commit();
    read_at(16'h0200, 3, "R6 overwrite");

    // R8: protected write acked but no commit
    wp = 1'b1;
    q = '{8'h3C};
    write_txn(16'h0012, q, "R8 protected data acked");
    wp = 1'b0;
    poll("R8 no commit cycle", 1);
    read_at(16'h0012, 1, "R8 array unchanged");

    // R9: partial data byte then repeated start; address kept
    bus_start();
    send_byte(8'hAA, "R9 select", 1);
    send_byte(8'h00, "R9 addr hi", 1);
    send_byte(8'h12, "R9 addr lo", 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'hAB, "R9 read select", 1);
    recv_byte(1'b0, got);
    chk("R9 address kept after abort", int'(got), int'(mm[16'h0012]));
    bus_stop();
    poll("R9 no commit after abort", 1);
    read_at(16'h0012, 1, "R9 contents untouched");

    // R10: current-address read continues after the last byte
    bus_start();
    send_byte(8'hAB, "R10 select", 1);
    recv_byte(1'b0, got);
    chk("R10 current address read", int'(got), int'(mm[16'h0013]));
    bus_stop();

    tick(10);
    chk("R1 idle at end", int'(sda_oe), 0);
    finish_run();
  end
endmodule